// File: doc/BRIEF.md
# Double-Buffered DAC Input Register

This block is the digital front end of a 16-bit digital-to-analog converter. It keeps two ranks of storage. The first rank is an input latch that a host fills. The second rank is the DAC register, which holds the code the converter actually drives. The host fills the input latch in one of two ways. In parallel byte mode, it writes the upper and lower halves of the word over an 8-bit bus, in either order. In serial mode, it shifts the word in one bit at a time. A separate level-sensitive transfer then moves the word into the DAC register, so the analog output changes in a single step.

Every input is sampled on the system clock. The chip-select strobe is the only control that acts on an edge: a write happens only in the clock cycle where the strobe is seen going from low to high. All other controls act while they are held at a level. These are the mode select, the two half-word enables, the load, the calibration request and the clear. The clear drives both ranks to a zero code. The level of a zero-select pin at the time of the clear decides whether that code is unipolar zero or bipolar zero.

Top module: `dac_input_regs`

## Requirements
- R1: After reset, `latch_word` and `dac_code` are both 0x0000.
- R2: When `byte_mode` is 1, a strobe rising edge writes `data_bus` into bits 15:8 of the input latch if `hi_sel` is 1, and into bits 7:0 if `lo_sel` is 1. When both are 1, the byte goes into both halves. When neither is 1, the latch is unchanged. The halves may be written in any order.
- R3: A write happens only in the cycle in which `cs_strobe` is first seen at 1 after being 0. Holding the strobe high, or taking it low, writes nothing, even if the data, the enables or the mode change meanwhile.
- R4: When `byte_mode` is 0, each strobe rising edge shifts the latch left by one bit and puts `ser_data` into bit 0. After 16 edges, the latch holds the 16 bits in the order they were sent, first bit in bit 15.
- R5: While `load_en` is 1, the DAC register takes the input latch value of the previous cycle on each clock, so it follows the latch one cycle behind.
- R6: While `load_en`, `cal_req` and `clr` are all 0, the DAC register keeps its value.
- R7: While `cal_req` is 1, the DAC register is loaded from the input latch in the same way as for `load_en`.
- R8: While `clr` is 1, both ranks are set on each clock to 0x0000 if `zero_bip` is 0, or to 0x8000 if `zero_bip` is 1. Strobe edges and loads seen during the clear have no effect.
- R9: A strobe edge sampled in clock cycle n changes `latch_word` after the clock edge that ends cycle n. A load seen in that same cycle transfers the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_strobe | input | 1 | Chip-select strobe; its rising edge writes the latch |
| byte_mode | input | 1 | 1 = parallel byte entry, 0 = serial entry |
| data_bus | input | 8 | Byte bus for parallel entry |
| ser_data | input | 1 | Serial data bit |
| hi_sel | input | 1 | Selects the upper half for a byte write |
| lo_sel | input | 1 | Selects the lower half for a byte write |
| load_en | input | 1 | Level-sensitive transfer from latch to DAC register |
| cal_req | input | 1 | Calibration request; also transfers the latch |
| clr | input | 1 | Level-sensitive clear of both ranks |
| zero_bip | input | 1 | Clear target: 0 unipolar zero, 1 bipolar zero |
| latch_word | output | 16 | First-rank input latch contents |
| dac_code | output | 16 | Second-rank DAC register contents |

## Verification
The bench holds the strobe high for several cycles while it changes the bus, the enables and the mode. A design that treats the strobe as a level would write again on each cycle, and the latch would pick up the changed data. The bench writes the halves in both orders, writes with both enables set, and writes with neither set. It shifts in a whole serial word, which exposes a reversed bit order or a lost first bit. It fires strobe edges and loads during a clear with the zero select at each level, so a design that lets the clear lose priority, or picks the wrong zero code, shows a wrong word. It also holds the load high while a write lands, which catches a DAC register that skips the one-cycle lag or fails to track.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int unsigned CODE_W = 16;
    localparam int unsigned BYTE_W = CODE_W / 2;
    localparam int unsigned LANES  = CODE_W / BYTE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [BYTE_W-1:0] byte_t;

    function automatic code_t zero_code(input logic bipolar);
        code_t z;
        z = '0;
        if (bipolar) z[CODE_W-1] = 1'b1;
        return z;
    endfunction
endpackage

// File: rtl/strobe_rise.sv
module strobe_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic rise_o
);
    typedef struct packed {
        logic level;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.level = strobe_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = strobe_i & ~st_q.level;
endmodule

// File: rtl/first_rank.sv
module first_rank
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise_i,
    input  logic  byte_mode_i,
    input  logic  hi_en_i,
    input  logic  lo_en_i,
    input  byte_t bus_i,
    input  logic  ser_i,
    input  logic  clr_i,
    input  logic  bip_i,
    output code_t word_o
);
    typedef struct packed {
        code_t word;
    } lat_st_t;

    lat_st_t st_d, st_q;
    logic [LANES-1:0] lane_wr;

    assign lane_wr[LANES-1] = hi_en_i;
    assign lane_wr[0]       = lo_en_i;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.word = zero_code(bip_i);
        end else if (rise_i) begin
            if (byte_mode_i) begin
                for (int ln = 0; ln < LANES; ln++) begin
                    if (lane_wr[ln]) st_d.word[ln*BYTE_W +: BYTE_W] = bus_i;
                end
            end else begin
                st_d.word = {st_q.word[CODE_W-2:0], ser_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.word;

    p_no_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rise_i && !clr_i) |=> $stable(word_o));

    p_hi_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && byte_mode_i && hi_en_i && !clr_i)
        |=> word_o[CODE_W-1 -: BYTE_W] == $past(bus_i));

    p_serial_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !byte_mode_i && !clr_i)
        |=> word_o == {$past(word_o[CODE_W-2:0]), $past(ser_i)});

    p_clear_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> word_o == zero_code($past(bip_i)));
endmodule

// File: rtl/dac_rank.sv
module dac_rank
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  xfer_i,
    input  logic  clr_i,
    input  logic  bip_i,
    input  code_t src_i,
    output code_t code_o
);
    typedef struct packed {
        code_t code;
    } dac_st_t;

    dac_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i)       st_d.code = zero_code(bip_i);
        else if (xfer_i) st_d.code = src_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;

    p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_i && !clr_i) |=> $stable(code_o));

    p_track_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_i && !clr_i) |=> code_o == $past(src_i));

    p_clear_dac_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> code_o == zero_code($past(bip_i)));
endmodule

// File: rtl/dac_input_regs.sv
module dac_input_regs
    import dacfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_strobe,
    input  logic        byte_mode,
    input  logic [7:0]  data_bus,
    input  logic        ser_data,
    input  logic        hi_sel,
    input  logic        lo_sel,
    input  logic        load_en,
    input  logic        cal_req,
    input  logic        clr,
    input  logic        zero_bip,
    output logic [15:0] latch_word,
    output logic [15:0] dac_code
);
    logic  wr_rise;
    code_t lat_word;
    code_t dac_word;

    strobe_rise u_rise (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (cs_strobe),
        .rise_o   (wr_rise)
    );

    first_rank u_lat (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (wr_rise),
        .byte_mode_i (byte_mode),
        .hi_en_i     (hi_sel),
        .lo_en_i     (lo_sel),
        .bus_i       (data_bus),
        .ser_i       (ser_data),
        .clr_i       (clr),
        .bip_i       (zero_bip),
        .word_o      (lat_word)
    );

    dac_rank u_dac (
        .clk    (clk),
        .rst_n  (rst_n),
        .xfer_i (load_en | cal_req),
        .clr_i  (clr),
        .bip_i  (zero_bip),
        .src_i  (lat_word),
        .code_o (dac_word)
    );

    assign latch_word = lat_word;
    assign dac_code   = dac_word;

    p_cal_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_req && !clr) |=> dac_code == $past(latch_word));
endmodule

// File: tb/tb_dac_input_regs.sv
`timescale 1ns/1ps
module tb_dac_input_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_strobe = 1'b0;
    logic        byte_mode = 1'b0;
    logic [7:0]  data_bus = '0;
    logic        ser_data = 1'b0;
    logic        hi_sel = 1'b0;
    logic        lo_sel = 1'b0;
    logic        load_en = 1'b0;
    logic        cal_req = 1'b0;
    logic        clr = 1'b0;
    logic        zero_bip = 1'b0;
    logic [15:0] latch_word;
    logic [15:0] dac_code;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // behavioural reference state
    int unsigned m_lat = 0;
    int unsigned m_dac = 0;
    bit          m_prev = 1'b0;

    always #2.5 clk = ~clk;

    dac_input_regs dut (
        .clk(clk), .rst_n(rst_n), .cs_strobe(cs_strobe), .byte_mode(byte_mode),
        .data_bus(data_bus), .ser_data(ser_data), .hi_sel(hi_sel), .lo_sel(lo_sel),
        .load_en(load_en), .cal_req(cal_req), .clr(clr), .zero_bip(zero_bip),
        .latch_word(latch_word), .dac_code(dac_code)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%04h expected 0x%04h", req, what, act, exp);
        end
    endtask

    // reference model, updated from the inputs sampled at each rising clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = 0; m_dac = 0; m_prev = 1'b0;
        end else begin
            int unsigned nl, nd;
            bit rise;
            rise = cs_strobe && !m_prev;
            nl = m_lat;
            nd = m_dac;
            if (clr) begin
                nl = zero_bip ? 32'h8000 : 32'h0000;
                nd = nl;
            end else begin
                if (load_en || cal_req) nd = m_lat;
                if (rise) begin
                    if (byte_mode) begin
                        if (hi_sel) nl = (nl & 32'h00FF) | (int'(data_bus) << 8);
                        if (lo_sel) nl = (nl & 32'hFF00) | int'(data_bus);
                    end else begin
                        nl = ((nl << 1) | int'(ser_data)) & 32'hFFFF;
                    end
                end
            end
            m_lat = nl;
            m_dac = nd;
            m_prev = cs_strobe;
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(latch_word == m_lat[15:0], cur_req, "latch_word", latch_word, m_lat);
            check(dac_code == m_dac[15:0], cur_req, "dac_code", dac_code, m_dac);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic byte_write(input bit hi, input bit lo, input logic [7:0] b);
        byte_mode = 1'b1; hi_sel = hi; lo_sel = lo; data_bus = b;
        tick();
        cs_strobe = 1'b1;
        tick();
        cs_strobe = 1'b0; hi_sel = 1'b0; lo_sel = 1'b0;
        tick();
    endtask

    task automatic serial_word(input logic [15:0] w);
        byte_mode = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            ser_data = w[i];
            tick();
            cs_strobe = 1'b1;
            tick();
            cs_strobe = 1'b0;
        end
        tick();
    endtask

    task automatic pulse_load();
        load_en = 1'b1; tick(); load_en = 1'b0; tick();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        cur_req = "R1";
        check(latch_word == 16'h0000, "R1", "reset latch", latch_word, 16'h0000);
        check(dac_code == 16'h0000, "R1", "reset dac", dac_code, 16'h0000);

        // R2: low half first, then high half
        cur_req = "R2";
        byte_write(1'b0, 1'b1, 8'h34);
        byte_write(1'b1, 1'b0, 8'h12);
        check(latch_word == 16'h1234, "R2", "lo then hi", latch_word, 16'h1234);
        check(dac_code == 16'h0000, "R6", "dac untouched before load", dac_code, 16'h0000);
        pulse_load();
        check(dac_code == 16'h1234, "R5", "load transfer", dac_code, 16'h1234);
        // R2: high half first, then low half
        byte_write(1'b1, 1'b0, 8'hAB);
        byte_write(1'b0, 1'b1, 8'hCD);
        check(latch_word == 16'hABCD, "R2", "hi then lo", latch_word, 16'hABCD);
        byte_write(1'b1, 1'b1, 8'h5A);
        check(latch_word == 16'h5A5A, "R2", "both enables", latch_word, 16'h5A5A);
        byte_write(1'b0, 1'b0, 8'hFF);
        check(latch_word == 16'h5A5A, "R2", "no enable", latch_word, 16'h5A5A);
        check(dac_code == 16'h1234, "R6", "dac holds", dac_code, 16'h1234);

        // R3: strobe held high while inputs change
        cur_req = "R3";
        byte_mode = 1'b1; hi_sel = 1'b0; lo_sel = 1'b1; data_bus = 8'h11;
        tick();
        cs_strobe = 1'b1;
        tick();
        data_bus = 8'h77; hi_sel = 1'b1; tick(3);
        byte_mode = 1'b0; ser_data = 1'b1; tick(2);
        cs_strobe = 1'b0; tick(2);
        hi_sel = 1'b0; lo_sel = 1'b0;
        check(latch_word == 16'h5A11, "R3", "single capture on held strobe", latch_word, 16'h5A11);

        // R4: serial word, first bit lands in bit 15
        cur_req = "R4";
        serial_word(16'hC3A5);
        check(latch_word == 16'hC3A5, "R4", "serial word", latch_word, 16'hC3A5);

        // R7: calibration request reloads DAC register
        cur_req = "R7";
        cal_req = 1'b1; tick(); cal_req = 1'b0; tick();
        check(dac_code == 16'hC3A5, "R7", "cal reload", dac_code, 16'hC3A5);

        // R5 / R9: load held high while a write lands; one-cycle lag
        cur_req = "R9";
        load_en = 1'b1;
        byte_mode = 1'b1; hi_sel = 1'b1; lo_sel = 1'b0; data_bus = 8'h0F;
        tick();
        cs_strobe = 1'b1;
        tick();
        check(latch_word == 16'h0FA5, "R9", "latch after edge", latch_word, 16'h0FA5);
        check(dac_code == 16'hC3A5, "R9", "dac lags one cycle", dac_code, 16'hC3A5);
        tick();
        check(dac_code == 16'h0FA5, "R5", "dac tracks latch", dac_code, 16'h0FA5);
        cs_strobe = 1'b0; hi_sel = 1'b0; load_en = 1'b0;
        tick();

        // R8: clear with unipolar select, strobe edge and load ignored
        cur_req = "R8";
        clr = 1'b1; zero_bip = 1'b0; load_en = 1'b1;
        byte_mode = 1'b1; hi_sel = 1'b1; lo_sel = 1'b1; data_bus = 8'h99;
        tick();
        cs_strobe = 1'b1;
        tick();
        check(latch_word == 16'h0000, "R8", "unipolar clear latch", latch_word, 16'h0000);
        check(dac_code == 16'h0000, "R8", "unipolar clear dac", dac_code, 16'h0000);
        // switch to bipolar while clear held
        zero_bip = 1'b1;
        tick();
        check(latch_word == 16'h8000, "R8", "bipolar clear latch", latch_word, 16'h8000);
        check(dac_code == 16'h8000, "R8", "bipolar clear dac", dac_code, 16'h8000);
        clr = 1'b0; load_en = 1'b0;
        tick(2);
        check(latch_word == 16'h8000, "R3", "held strobe after clear no write", latch_word, 16'h8000);
        cs_strobe = 1'b0; hi_sel = 1'b0; lo_sel = 1'b0; zero_bip = 1'b0;
        tick();
        byte_write(1'b0, 1'b1, 8'h01);
        check(latch_word == 16'h8001, "R2", "write after clear", latch_word, 16'h8001);
        check(dac_code == 16'h8000, "R6", "dac holds after clear", dac_code, 16'h8000);

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule